// File: doc/BRIEF.md
# Shadowed Comparator Threshold Register Unit

This unit holds the digital threshold codes for two comparator reference DACs, a high channel and a low channel. Software writes a shadow value for each channel. Each channel also has an active value that software can read but not write, and that active value drives the channel's code output. A per-channel control bit sets when the active value takes the shadow. In immediate mode it does so at once. In sync mode it does so only on a PWM sync-period strobe. A second per-channel bit replaces the shadow as the source with an external ramp-generator bus.

The unit also watches the two active codes. It raises an ordering flag when the high threshold is not above the low threshold. A channel parked at the all-ones code is treated as unused and never contributes to the flag. Access is through a single-cycle write port and a combinational read port that share one address.

Top module: `cmp_thresh_regs`

## Requirements
- R1: While reset is asserted, both shadow and both active values are zero, the control register is zero (immediate mode, shadow source), and reads of every address return zero.
- R2: Address map: 0 control (bit0 high sync mode, bit1 high ramp source, bit2 low sync mode, bit3 low ramp source; other bits read 0), 1 high shadow, 2 high active, 3 low shadow, 4 low active. Unmapped addresses read 0. rdata_o reflects the addressed register combinationally.
- R3: In immediate mode with shadow source, a shadow write appears on the active value and the code output at the clock edge that stores it.
- R4: In sync mode with shadow source, the active value holds between sync strobes however often the shadow changes. On a strobe it takes the latest shadow value.
- R5: In sync mode, a shadow write made in the same cycle as the strobe is the value loaded at that strobe.
- R6: With ramp source selected, the active value takes ramp_i at every clock edge. Shadow writes are still stored and read back but are not applied.
- R7: Writes to an active-value address change nothing.
- R8: The two channels are independent: writes, modes and sources of one never alter the other's code.
- R9: order_err_o is 1 whenever neither active code equals 0xFFF and the high active code is less than or equal to the low one, equal codes included. Otherwise it is 0.
- R10: A channel whose active code is 0xFFF counts as parked, and order_err_o is then 0 regardless of the other code.
- R11: When ramp source is cleared, an immediate-mode channel takes its shadow at the next edge. A sync-mode channel keeps the last ramp value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 12 | Write data |
| rdata_o | output | 12 | Read data for addr_i |
| sync_i | input | 1 | PWM sync-period strobe |
| ramp_i | input | 12 | Ramp-generator code |
| hi_code_o | output | 12 | High channel DAC code (active value) |
| lo_code_o | output | 12 | Low channel DAC code (active value) |
| order_err_o | output | 1 | High threshold not above low threshold |

## Verification
Two events can land in the same cycle: a shadow write and the sync strobe, and a control write that changes the source or mode while the old setting is still in force. The bench drives both in a single step. A high-shadow write with sync_i high must load the new value at once. A control write that enables or disables the ramp must still act under the old control for that cycle and under the new control from the following edge. Each step's expected codes, flag and read value come from a requirement-level model and are queued for a monitor to compare after the edge.

// File: rtl/cmp_thresh_pkg.sv
package cmp_thresh_pkg;
  localparam int unsigned CTRL_W = 4;

  typedef struct packed {
    logic lo_ramp;
    logic lo_sync;
    logic hi_ramp;
    logic hi_sync;
  } ctrl_t;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_HI_SHD = 1;
  localparam int unsigned A_HI_ACT = 2;
  localparam int unsigned A_LO_SHD = 3;
  localparam int unsigned A_LO_ACT = 4;
endpackage

// File: rtl/thr_ctrl_reg.sv
module thr_ctrl_reg
  import cmp_thresh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= ctrl_t'(wdata_i);
  end
endmodule

// File: rtl/thr_chan.sv
module thr_chan #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shd_we_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              sync_mode_i,
  input  logic              ramp_sel_i,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] ramp_i,
  output logic [CODE_W-1:0] shadow_o,
  output logic [CODE_W-1:0] active_o
);
  logic [CODE_W-1:0] shd_d, act_d;

  assign shd_d = shd_we_i ? wdata_i : shadow_o;

  // same-cycle write wins at a strobe: shd_d already carries it
  always_comb begin
    if (ramp_sel_i)        act_d = ramp_i;
    else if (!sync_mode_i) act_d = shd_d;
    else if (sync_i)       act_d = shd_d;
    else                   act_d = active_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      active_o <= '0;
    end else begin
      shadow_o <= shd_d;
      active_o <= act_d;
    end
  end
endmodule

// File: rtl/thr_order_mon.sv
module thr_order_mon #(
  parameter int unsigned CODE_W = 12
) (
  input  logic [CODE_W-1:0] hi_i,
  input  logic [CODE_W-1:0] lo_i,
  output logic              err_o
);
  localparam logic [CODE_W-1:0] PARK = {CODE_W{1'b1}};
  logic hi_used, lo_used;
  assign hi_used = (hi_i != PARK);
  assign lo_used = (lo_i != PARK);
  assign err_o   = hi_used && lo_used && (hi_i <= lo_i);
endmodule

// File: rtl/cmp_thresh_regs.sv
module cmp_thresh_regs
  import cmp_thresh_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] rdata_o,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] ramp_i,
  output logic [CODE_W-1:0] hi_code_o,
  output logic [CODE_W-1:0] lo_code_o,
  output logic              order_err_o
);
  localparam int unsigned NUM_CH = 2;

  ctrl_t             ctrl_q;
  logic              ctrl_we;
  logic [CODE_W-1:0] shadow [NUM_CH];
  logic [CODE_W-1:0] active [NUM_CH];
  logic              mode_sync [NUM_CH];
  logic              mode_ramp [NUM_CH];

  assign ctrl_we = we_i && (addr_i == ADDR_W'(A_CTRL));

  thr_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we),
    .wdata_i(wdata_i[CTRL_W-1:0]),
    .ctrl_o (ctrl_q)
  );

  assign mode_sync[0] = ctrl_q.hi_sync;
  assign mode_ramp[0] = ctrl_q.hi_ramp;
  assign mode_sync[1] = ctrl_q.lo_sync;
  assign mode_ramp[1] = ctrl_q.lo_ramp;

  // channel 0 = high, 1 = low; shadow at 1+2i, active at 2+2i
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic shd_we;
    assign shd_we = we_i && (addr_i == ADDR_W'(1 + 2 * i));
    thr_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shd_we_i   (shd_we),
      .wdata_i    (wdata_i),
      .sync_mode_i(mode_sync[i]),
      .ramp_sel_i (mode_ramp[i]),
      .sync_i     (sync_i),
      .ramp_i     (ramp_i),
      .shadow_o   (shadow[i]),
      .active_o   (active[i])
    );
  end

  assign hi_code_o = active[0];
  assign lo_code_o = active[1];

  thr_order_mon #(.CODE_W(CODE_W)) u_order (
    .hi_i (active[0]),
    .lo_i (active[1]),
    .err_o(order_err_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_CTRL):   rdata_o = {{(CODE_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_W'(A_HI_SHD): rdata_o = shadow[0];
      ADDR_W'(A_HI_ACT): rdata_o = active[0];
      ADDR_W'(A_LO_SHD): rdata_o = shadow[1];
      ADDR_W'(A_LO_ACT): rdata_o = active[1];
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmp_thresh_regs_chk.sv
module cmp_thresh_regs_chk #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CODE_W-1:0] wdata_i,
  input logic              sync_i,
  input logic [CODE_W-1:0] ramp_i,
  input logic [CODE_W-1:0] hi_code_o,
  input logic [CODE_W-1:0] lo_code_o,
  input logic              order_err_o,
  input logic [3:0]        ctrl_q
);
  localparam logic [CODE_W-1:0] PARK = {CODE_W{1'b1}};

  // R3
  imm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(1) && !ctrl_q[0] && !ctrl_q[1]) |=> hi_code_o == $past(wdata_i));

  // R4
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[0] && !ctrl_q[1] && !sync_i) |=> $stable(hi_code_o));

  // R5
  sync_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(1) && ctrl_q[0] && !ctrl_q[1] && sync_i) |=> hi_code_o == $past(wdata_i));

  // R6
  ramp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[3] |=> lo_code_o == $past(ramp_i));

  // R9
  order_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_err_o |-> hi_code_o <= lo_code_o);

  // R10
  parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_code_o == PARK || lo_code_o == PARK) |-> !order_err_o);
endmodule

bind cmp_thresh_regs cmp_thresh_regs_chk #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .sync_i     (sync_i),
  .ramp_i     (ramp_i),
  .hi_code_o  (hi_code_o),
  .lo_code_o  (lo_code_o),
  .order_err_o(order_err_o),
  .ctrl_q     (ctrl_q)
);

// File: tb/sim_cmp_thresh_regs.sv
module sim_cmp_thresh_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [11:0] wdata_i = '0;
  logic [11:0] rdata_o;
  logic        sync_i = 1'b0;
  logic [11:0] ramp_i = '0;
  logic [11:0] hi_code_o, lo_code_o;
  logic        order_err_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  cmp_thresh_regs u0 (.*);

  typedef struct {
    string       req;
    logic [11:0] hi, lo, rd;
    logic        err;
  } exp_t;
  exp_t q[$];

  // requirement-level model state
  logic [3:0]  m_ctrl = '0;
  logic [11:0] m_hs = '0, m_ha = '0, m_ls = '0, m_la = '0;

  function automatic logic [11:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {8'h0, m_ctrl};
      3'd1: return m_hs;
      3'd2: return m_ha;
      3'd3: return m_ls;
      3'd4: return m_la;
      default: return 12'h0;
    endcase
  endfunction

  function automatic logic m_err(input logic [11:0] h, input logic [11:0] l);
    return (h != 12'hFFF) && (l != 12'hFFF) && (h <= l);
  endfunction

  task automatic step(input string req, input logic we, input logic [2:0] a,
                      input logic [11:0] d, input logic s, input logic [11:0] r);
    logic [11:0] hs_n, ls_n;
    exp_t e;
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; sync_i = s; ramp_i = r;
    hs_n = (we && a == 3'd1) ? d : m_hs;
    ls_n = (we && a == 3'd3) ? d : m_ls;
    if (m_ctrl[1])      m_ha = r;
    else if (!m_ctrl[0] || s) m_ha = hs_n;
    if (m_ctrl[3])      m_la = r;
    else if (!m_ctrl[2] || s) m_la = ls_n;
    m_hs = hs_n; m_ls = ls_n;
    if (we && a == 3'd0) m_ctrl = d[3:0];
    e.req = req; e.hi = m_ha; e.lo = m_la; e.rd = m_read(a); e.err = m_err(m_ha, m_la);
    q.push_back(e);
  endtask

  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (hi_code_o !== e.hi || lo_code_o !== e.lo || rdata_o !== e.rd || order_err_o !== e.err) begin
        n_fail++;
        $display("FAIL %s hi=%h/%h lo=%h/%h rd=%h/%h err=%b/%b (act/exp)",
                 e.req, hi_code_o, e.hi, lo_code_o, e.lo, rdata_o, e.rd, order_err_o, e.err);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state, equal zero codes raise the order flag (R9)
    n_run++;
    if (hi_code_o !== 12'h0 || lo_code_o !== 12'h0 || rdata_o !== 12'h0 || order_err_o !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 hi=%h lo=%h rd=%h err=%b exp 000 000 000 1",
               hi_code_o, lo_code_o, rdata_o, order_err_o);
    end
    rst_ni = 1'b1;
    step("R2", 1'b0, 3'd2, 12'h0, 1'b0, 12'h0);
    step("R3", 1'b1, 3'd1, 12'h800, 1'b0, 12'h0);
    step("R8", 1'b1, 3'd3, 12'h100, 1'b0, 12'h0);
    step("R2", 1'b0, 3'd0, 12'h0, 1'b0, 12'h0);
    step("R7", 1'b1, 3'd2, 12'h123, 1'b0, 12'h0);
    step("R7", 1'b1, 3'd4, 12'h456, 1'b0, 12'h0);
    step("R2", 1'b0, 3'd7, 12'h0, 1'b0, 12'h0);
    step("R4", 1'b1, 3'd0, 12'h001, 1'b0, 12'h0);
    step("R4", 1'b1, 3'd1, 12'h900, 1'b0, 12'h0);
    step("R4", 1'b1, 3'd1, 12'hA00, 1'b0, 12'h0);
    step("R4", 1'b0, 3'd2, 12'h0, 1'b0, 12'h0);
    step("R8", 1'b1, 3'd3, 12'h180, 1'b0, 12'h0);
    step("R4", 1'b0, 3'd2, 12'h0, 1'b1, 12'h0);
    step("R5", 1'b1, 3'd1, 12'h050, 1'b1, 12'h0);
    step("R9", 1'b0, 3'd2, 12'h0, 1'b0, 12'h0);
    step("R10", 1'b1, 3'd3, 12'hFFF, 1'b0, 12'h0);
    step("R9", 1'b1, 3'd3, 12'h050, 1'b0, 12'h0);
    step("R6", 1'b1, 3'd0, 12'h009, 1'b0, 12'h030);
    step("R6", 1'b1, 3'd3, 12'h007, 1'b0, 12'h031);
    step("R6", 1'b0, 3'd3, 12'h0, 1'b0, 12'h032);
    step("R6", 1'b0, 3'd4, 12'h0, 1'b1, 12'h033);
    step("R11", 1'b1, 3'd0, 12'h001, 1'b0, 12'h034);
    step("R11", 1'b0, 3'd4, 12'h0, 1'b0, 12'h035);
    step("R11", 1'b1, 3'd0, 12'h003, 1'b0, 12'h400);
    step("R6", 1'b1, 3'd1, 12'h0AA, 1'b0, 12'h401);
    step("R11", 1'b1, 3'd0, 12'h001, 1'b0, 12'h402);
    step("R11", 1'b0, 3'd2, 12'h0, 1'b0, 12'h403);
    step("R11", 1'b0, 3'd1, 12'h0, 1'b0, 12'h404);
    step("R11", 1'b0, 3'd2, 12'h0, 1'b1, 12'h405);
    step("R10", 1'b1, 3'd0, 12'h000, 1'b0, 12'h0);
    step("R10", 1'b1, 3'd1, 12'hFFF, 1'b0, 12'h0);
    step("R2", 1'b0, 3'd0, 12'h0, 1'b0, 12'h0);
    @(negedge clk_i);
    we_i = 1'b0; sync_i = 1'b0;
    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule